// File: doc/BRIEF.md
# Fixed-Capacity Streaming Itemset Counter

This block keeps approximate occurrence counts of itemsets in an unbounded stream of transactions. Storage is a table with exactly K slots, so its size never depends on how long the stream runs. Each transaction is an N-bit mask over the item alphabet. Once a transaction is accepted, the block steps through every non-empty subset of it, one subset per cycle. On each step it compares the subset with all K stored itemsets at once. A match bumps the matching count. A miss goes into a free slot, or, when the table is full, into a small buffer of replacement candidates.

After the last subset there is one replacement cycle. In that cycle, slots that hold the current minimum count are overwritten with buffered candidates, and each new slot starts at the error offset plus one. The error offset is a global value that rises by one each time a replacement takes place. A host sends a transaction when `ready` is high and reads results through a combinational read port.

Top module: `itemset_tally`

## Requirements
- R1: After reset all K slots are invalid, the error offset reads 0 and `ready` is high.
- R2: An accepted transaction T keeps `ready` low for exactly 2^|T| cycles: one cycle for each non-empty subset and one replacement cycle. Subsets are visited starting at T and stepping s -> (s-1) & T until the last non-zero value.
- R3: A subset equal to a valid stored itemset increases that slot's count by 1.
- R4: A subset with no match, while a slot is invalid, is written into the lowest-index invalid slot with count 1.
- R5: A subset with no match while all slots are valid becomes a candidate. It leaves the table unchanged during the subset walk.
- R6: In the replacement cycle, let M be the set of valid slots holding the minimum count. min(|M|, number of candidates) of those slots, lowest index first, take candidates in arrival order, each with count equal to the error offset plus 1.
- R7: The error offset stays the same after a transaction that produced no candidate. Otherwise it becomes the previous offset plus 1, which equals the count given to new slots. This holds both when |M| exceeds the candidate count and when it does not.
- R8: At most CD candidates are kept per transaction. Further candidates are dropped.
- R9: `txn_valid` has no effect when the mask is zero or when `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction offered |
| txn_mask | input | N | Item bitmask of the transaction, bit i = item i |
| ready | output | 1 | Idle and able to accept a transaction |
| rd_idx | input | clog2(K) | Slot selected for readout |
| rd_valid | output | 1 | Selected slot holds an itemset |
| rd_set | output | N | Itemset mask of the selected slot |
| rd_count | output | CW | Count of the selected slot |
| err_delta | output | CW | Current error offset |

## Verification
The assertions assume that the host offers a transaction only as a single-cycle pulse while `ready` is high. They also assume that counts never come close to wrapping, so the error offset is modelled as only holding or rising by one. The stimulus keeps to a few short transactions on a small table, so counts stay tiny. It includes one pulse offered while the block is busy and one pulse with an empty mask, and both must leave every slot unchanged. Mid-stream table contents are compared only while `ready` is high, when the read port is stable.

// File: rtl/itemset_tally.sv
module itemset_tally #(
  parameter int N  = 8,
  parameter int K  = 8,
  parameter int CW = 16,
  parameter int CD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_valid,
  input  logic [N-1:0]  txn_mask,
  output logic          ready,
  input  logic [(K>1 ? $clog2(K) : 1)-1:0] rd_idx,
  output logic          rd_valid,
  output logic [N-1:0]  rd_set,
  output logic [CW-1:0] rd_count,
  output logic [CW-1:0] err_delta
);
  localparam int IW  = (K > 1) ? $clog2(K) : 1;
  localparam int CIW = $clog2(CD + 1);

  typedef enum logic [1:0] {IDLE, WALK, SWAP} st_t;

  st_t             st_q;
  logic [N-1:0]    set_q [K];
  logic [CW-1:0]   cnt_q [K];
  logic [K-1:0]    val_q;
  logic [CD*N-1:0] cand_q;
  logic [CIW-1:0]  cand_n;
  logic [N-1:0]    sub_q, txn_q;
  logic [CW-1:0]   delta_q;

  logic            hit, full;
  logic [IW-1:0]   hit_idx, free_idx;
  logic [CW-1:0]   min_cnt;
  logic [K-1:0]    is_min;
  int              rank [K];
  logic [N-1:0]    nxt;

  assign ready     = (st_q == IDLE);
  assign full      = &val_q;
  assign nxt       = (sub_q - N'(1)) & txn_q;
  assign rd_valid  = val_q[rd_idx];
  assign rd_set    = set_q[rd_idx];
  assign rd_count  = cnt_q[rd_idx];
  assign err_delta = delta_q;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    free_idx = '0;
    for (int i = 0; i < K; i++)
      if (val_q[i] && set_q[i] == sub_q) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    for (int i = K-1; i >= 0; i--)
      if (!val_q[i]) free_idx = IW'(i);
  end

  always_comb begin
    int acc;
    min_cnt = '1;
    for (int i = 0; i < K; i++)
      if (val_q[i] && cnt_q[i] < min_cnt) min_cnt = cnt_q[i];
    acc = 0;
    for (int i = 0; i < K; i++) begin
      is_min[i] = val_q[i] && (cnt_q[i] == min_cnt);
      rank[i] = acc;
      if (is_min[i]) acc = acc + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      val_q   <= '0;
      cand_q  <= '0;
      cand_n  <= '0;
      sub_q   <= '0;
      txn_q   <= '0;
      delta_q <= '0;
      for (int i = 0; i < K; i++) begin
        set_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      case (st_q)
        IDLE: if (txn_valid && |txn_mask) begin
          txn_q  <= txn_mask;
          sub_q  <= txn_mask;
          cand_n <= '0;
          st_q   <= WALK;
        end
        WALK: begin
          if (hit)
            cnt_q[hit_idx] <= cnt_q[hit_idx] + CW'(1);
          else if (!full) begin
            val_q[free_idx] <= 1'b1;
            set_q[free_idx] <= sub_q;
            cnt_q[free_idx] <= CW'(1);
          end else if (int'(cand_n) < CD) begin
            cand_q[int'(cand_n)*N +: N] <= sub_q;
            cand_n <= cand_n + CIW'(1);
          end
          sub_q <= nxt;
          if (nxt == '0) st_q <= SWAP;
        end
        SWAP: begin
          if (cand_n != '0) begin
            for (int i = 0; i < K; i++)
              if (is_min[i] && rank[i] < int'(cand_n)) begin
                set_q[i] <= cand_q[rank[i]*N +: N];
                cnt_q[i] <= delta_q + CW'(1);
              end
            delta_q <= delta_q + CW'(1);
          end
          st_q <= IDLE;
        end
        default: st_q <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/itemset_tally_chk.sv
module itemset_tally_chk #(
  parameter int N  = 8,
  parameter int K  = 8,
  parameter int CW = 16,
  parameter int CD = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     txn_valid,
  input logic [N-1:0]             txn_mask,
  input logic                     ready,
  input logic [K-1:0]             val_q,
  input logic [CW-1:0]            delta_q,
  input logic [$clog2(CD+1)-1:0]  cand_n
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && txn_valid && (txn_mask != '0) |=> !ready);

  // R9
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !(txn_valid && (txn_mask != '0)) |=> ready && $stable(val_q));

  // R7
  delta_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_q == $past(delta_q)) || (delta_q == $past(delta_q) + CW'(1)));

  // R7
  delta_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> $stable(delta_q));

  // R4
  no_slot_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(val_q) >= $countones($past(val_q)));

  // R8
  cand_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cand_n) <= CD);
endmodule

bind itemset_tally itemset_tally_chk #(.N(N), .K(K), .CW(CW), .CD(CD)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_mask(txn_mask),
  .ready(ready), .val_q(val_q), .delta_q(delta_q), .cand_n(cand_n)
);

// File: tb/test_itemset_tally.sv
`timescale 1ns/1ps
module test_itemset_tally;
  localparam int N = 8, K = 4, CW = 16, CD = 2;

  typedef struct {
    int    idx;
    logic  v;
    logic [N-1:0]  s;
    logic [CW-1:0] c;
    string req;
  } exp_t;

  logic clk = 0, rst_n = 0, txn_valid = 0;
  logic [N-1:0] txn_mask = '0;
  logic [1:0] rd_idx = '0;
  logic ready, rd_valid;
  logic [N-1:0] rd_set;
  logic [CW-1:0] rd_count, err_delta;

  int checks = 0, errors = 0;
  exp_t q[$];

  logic          m_v [K];
  logic [N-1:0]  m_s [K];
  int            m_c [K];
  int            m_delta = 0;

  itemset_tally #(.N(N), .K(K), .CW(CW), .CD(CD)) i_itemset_tally (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_mask(txn_mask),
    .ready(ready), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_set(rd_set),
    .rd_count(rd_count), .err_delta(err_delta));

  always #4 clk = ~clk;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  always @(negedge clk) if (q.size() > 0) begin
    exp_t e;
    e = q.pop_front();
    checks++;
    if (rd_valid !== e.v || (e.v && (rd_set !== e.s || rd_count !== e.c))) begin
      errors++;
      $display("FAIL %s slot %0d: got v=%b set=%h cnt=%0d, expected v=%b set=%h cnt=%0d",
               e.req, e.idx, rd_valid, rd_set, rd_count, e.v, e.s, e.c);
    end
  end

  task automatic ref_txn(input logic [N-1:0] t);
    logic [N-1:0] s, cand[$];
    int hi, mn, r;
    if (t == '0) return;
    s = t;
    do begin
      hi = -1;
      for (int i = 0; i < K; i++) if (m_v[i] && m_s[i] == s) hi = i;
      if (hi >= 0) m_c[hi]++;
      else begin
        int fr = -1;
        for (int i = K-1; i >= 0; i--) if (!m_v[i]) fr = i;
        if (fr >= 0) begin m_v[fr] = 1; m_s[fr] = s; m_c[fr] = 1; end
        else if (cand.size() < CD) cand.push_back(s);
      end
      s = (s - 1) & t;
    end while (s != '0);
    if (cand.size() > 0) begin
      mn = 1 << 30;
      for (int i = 0; i < K; i++) if (m_v[i] && m_c[i] < mn) mn = m_c[i];
      r = 0;
      for (int i = 0; i < K; i++)
        if (m_v[i] && m_c[i] == mn) begin
          if (r < cand.size()) begin m_s[i] = cand[r]; m_c[i] = m_delta + 1; end
          r++;
        end
      m_delta++;
    end
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < K; i++) begin
      exp_t e;
      @(posedge clk);
      rd_idx = 2'(i);
      e.idx = i; e.v = m_v[i]; e.s = m_s[i]; e.c = CW'(m_c[i]); e.req = req;
      q.push_back(e);
    end
    wait (q.size() == 0);
    @(negedge clk);
    checks++;
    if (err_delta !== CW'(m_delta)) begin
      errors++;
      $display("FAIL R7 delta: got %0d expected %0d", err_delta, m_delta);
    end
  endtask

  task automatic send(input logic [N-1:0] t, input logic [N-1:0] poke, input string req);
    int busy, want;
    @(negedge clk);
    txn_valid = 1; txn_mask = t;
    @(negedge clk);
    txn_valid = 0; txn_mask = '0;
    busy = 0;
    while (!ready) begin
      busy++;
      if (busy == 1 && poke != '0) begin txn_valid = 1; txn_mask = poke; end
      else txn_valid = 0;
      @(negedge clk);
    end
    txn_valid = 0;
    ref_txn(t);
    want = (t == '0) ? 0 : (1 << $countones(t));
    checks++;
    if (busy != want) begin
      errors++;
      $display("FAIL R2 busy cycles for %h: got %0d expected %0d", t, busy, want);
    end
    check_table(req);
  endtask

  initial begin
    for (int i = 0; i < K; i++) begin m_v[i] = 0; m_s[i] = '0; m_c[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 ready after reset: got %b expected 1", ready);
    end
    check_table("R1");
    // R4 fill: ab, b, a into slots 0..2
    send(8'h03, 8'h00, "R4");
    // R3 a counts, R5 c candidate, R6 replaces slot 0, R7 delta 0->1
    send(8'h05, 8'h00, "R6");
    // R8 four candidates, two kept; R3 on a, c, ac
    send(8'h0D, 8'h00, "R8");
    // R9 empty mask offered
    send(8'h00, 8'h00, "R9");
    // R9 pulse while busy ignored; R3 hit on a
    send(8'h01, 8'h80, "R9");
    // R5 all miss, R6 several minima
    send(8'hF0, 8'h00, "R5");
    // R2 full mask, 256 busy cycles
    send(8'hFF, 8'h00, "R2");
    send(8'h05, 8'h00, "R3");
    report();
  end
endmodule